// File: doc/BRIEF.md
# Four-State Serial Pattern Machine

This block is a small clocked machine that watches a one-bit serial input and keeps two state bits in D flip-flops. The high bit `Q1` is loaded with `x OR Q0` and the low bit `Q0` is loaded with `x AND Q1`. The output is high only when both state bits are set. As a result, the output rises one cycle after the input has been high for two edges in a row, and it stays high for as long as the input stays high.

The four states are named by their two-bit code, with `Q1` as the high bit:

- `ST_IDLE` is 00.
- `ST_ORPHAN` is 01.
- `ST_ARMED` is 10.
- `ST_MATCH` is 11.

The named transitions are:

- idle-hold: `ST_IDLE` with x=0 stays in `ST_IDLE`.
- idle-arm: `ST_IDLE` with x=1 goes to `ST_ARMED`.
- orphan-recover: `ST_ORPHAN` with any x goes to `ST_ARMED`.
- armed-drop: `ST_ARMED` with x=0 goes to `ST_IDLE`.
- armed-hit: `ST_ARMED` with x=1 goes to `ST_MATCH`.
- match-fall: `ST_MATCH` with x=0 goes to `ST_ARMED`.
- match-hold: `ST_MATCH` with x=1 stays in `ST_MATCH`.

The equations can never produce code 01, so `ST_ORPHAN` cannot be reached once reset has been applied. Its transition is still defined, so that a corrupted state recovers.

The present state is brought out on a port so that the sequence can be observed.

Top module: `seqm_core`

## Requirements
- R1: When `rst` is high at a rising edge of `clk`, the state becomes 00 (`ST_IDLE`) after that edge, whatever `x` is.
- R2: `y` is 1 exactly when the present state is 11 (`ST_MATCH`), and 0 in every other state. It depends only on the present state.
- R3: Without reset, the high state bit after an edge equals `x OR Q0`, using the values present before that edge.
- R4: Without reset, the low state bit after an edge equals `x AND Q1`, using the values present before that edge.
- R5: From 00, x=0 holds the state at 00 and x=1 moves it to 10.
- R6: From 10, x=0 moves the state to 00 and x=1 moves it to 11.
- R7: From 11, x=0 moves the state to 10 and x=1 holds it at 11.
- R8: The `state` port shows `{Q1, Q0}` with `Q1` in bit 1.
- R9: After reset, code 01 never appears on `state`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset to 00 |
| x | input | 1 | Serial data input |
| y | output | 1 | High while the state is 11 |
| state | output | 2 | Present state `{Q1, Q0}` |

## Verification
A value of `x` applied before a rising edge shows up in `state` after exactly one edge. `y` follows the new state in the same cycle, with no further delay. The bench therefore changes `x` and `rst` only on falling edges. It advances its own reference state once per rising edge and compares both `state` and `y` on the following falling edge. Each comparison is tagged with the transition rule or equation it exercises.

// File: rtl/seqm_pkg.sv
package seqm_pkg;
    localparam int STATE_W = 2;

    typedef enum logic [STATE_W-1:0] {
        ST_IDLE   = 2'b00,
        ST_ORPHAN = 2'b01,
        ST_ARMED  = 2'b10,
        ST_MATCH  = 2'b11
    } seqm_state_e;
endpackage

// File: rtl/seqm_next.sv
module seqm_next
    import seqm_pkg::*;
(
    input  seqm_state_e cur,
    input  logic        x,
    output seqm_state_e nxt
);
    // Transition table named after the brief; equivalent to Q1'=x|Q0, Q0'=x&Q1.
    always_comb begin
        unique case (cur)
            ST_IDLE:   nxt = x ? ST_ARMED : ST_IDLE;   // idle-arm / idle-hold
            ST_ORPHAN: nxt = ST_ARMED;                 // orphan-recover
            ST_ARMED:  nxt = x ? ST_MATCH : ST_IDLE;   // armed-hit / armed-drop
            ST_MATCH:  nxt = x ? ST_MATCH : ST_ARMED;  // match-hold / match-fall
        endcase
    end
endmodule

// File: rtl/seqm_out.sv
module seqm_out
    import seqm_pkg::*;
(
    input  seqm_state_e cur,
    output logic        y
);
    always_comb begin
        unique case (cur)
            ST_MATCH: y = 1'b1;
            ST_IDLE, ST_ORPHAN, ST_ARMED: y = 1'b0;
        endcase
    end
endmodule

// File: rtl/seqm_reg.sv
module seqm_reg
    import seqm_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  seqm_state_e nxt,
    output seqm_state_e cur
);
    always_ff @(posedge clk) begin
        if (rst) cur <= ST_IDLE;
        else     cur <= nxt;
    end

    // R1: synchronous reset lands in idle
    a_r1_reset_idle: assert property (@(posedge clk) rst |=> cur == ST_IDLE);
endmodule

// File: rtl/seqm_core.sv
module seqm_core
    import seqm_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               x,
    output logic               y,
    output logic [STATE_W-1:0] state
);
    seqm_state_e cur_s;
    seqm_state_e nxt_s;

    seqm_next u_next (.cur(cur_s), .x(x), .nxt(nxt_s));
    seqm_reg  u_reg  (.clk(clk), .rst(rst), .nxt(nxt_s), .cur(cur_s));
    seqm_out  u_out  (.cur(cur_s), .y(y));

    assign state = cur_s;

    // R3: high bit follows x OR Q0
    a_r3_q1_eq: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state[1] == ($past(x) | $past(state[0])));
    // R4: low bit follows x AND Q1
    a_r4_q0_eq: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> state[0] == ($past(x) & $past(state[1])));
    // R2: output high only in match
    a_r2_y_match: assert property (@(posedge clk) y == (state == 2'b11));
    // R7: match-hold
    a_r7_match_hold: assert property (@(posedge clk) disable iff (rst)
        (state == 2'b11 && x) |=> state == 2'b11);
    // R9: code 01 is never entered from a legal state
    a_r9_no_orphan: assert property (@(posedge clk) disable iff (rst)
        (state != 2'b01) |=> state != 2'b01);
endmodule

// File: tb/seqm_core_tb.sv
module seqm_core_tb;
    localparam time CLK_PERIOD = 10ns;
    localparam int  RAND_CYCLES = 600;
    localparam int  WATCHDOG = 50000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       x   = 1'b0;
    logic       y;
    logic [1:0] state;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    logic [1:0] exp_st = 2'b00;

    seqm_core u_dut (.clk(clk), .rst(rst), .x(x), .y(y), .state(state));

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [1:0] ref_next(input logic [1:0] s, input logic xi);
        return {xi | s[0], xi & s[1]};
    endfunction

    function automatic logic ref_y(input logic [1:0] s);
        return s[1] & s[0];
    endfunction

    task automatic check(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // Drive on falling edge, one rising edge, check on next falling edge.
    task automatic step(input logic xi, input logic ri);
        logic [1:0] prev = exp_st;
        string rule;
        x   = xi;
        rst = ri;
        exp_st = ri ? 2'b00 : ref_next(prev, xi);
        @(posedge clk);
        @(negedge clk);
        if (ri)                 rule = "R1";
        else if (prev == 2'b00) rule = "R5";
        else if (prev == 2'b10) rule = "R6";
        else                    rule = "R7";
        check({rule, " state (R8 encoding)"}, state, exp_st);
        check("R2 y", {1'b0, y}, {1'b0, ref_y(exp_st)});
        if (!ri) begin
            check("R3 high bit", {1'b0, state[1]}, {1'b0, xi | prev[0]});
            check("R4 low bit", {1'b0, state[0]}, {1'b0, xi & prev[1]});
            check("R9 no 01", {1'b0, state == 2'b01}, 2'b00);
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected<=%0d", cycles, WATCHDOG);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        step(1'b1, 1'b1);                       // R1 reset with x high
        step(1'b0, 1'b0);                       // R5 idle-hold
        step(1'b1, 1'b0);                       // R5 idle-arm
        step(1'b0, 1'b0);                       // R6 armed-drop
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);                       // R6 armed-hit, y rises
        step(1'b1, 1'b0);                       // R7 match-hold
        step(1'b0, 1'b0);                       // R7 match-fall
        step(1'b1, 1'b0);
        step(1'b1, 1'b1);                       // R1 reset out of match
        for (int i = 0; i < RAND_CYCLES; i++) begin
            step(1'($urandom % 2), ($urandom % 32) == 0);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule